// File: doc/BRIEF.md
# Masked Packed Signed-Integer to Half-Precision Converter

This block turns up to eight packed signed 64-bit integers into IEEE 754 half-precision values. The eight results are packed into a 128-bit destination, under a per-lane write mask. A vector-length select sets how many lanes take part: 2, 4 or 8. The results fill the low quarter of the source width, and every destination bit above that quarter reads zero. The source can be taken lane by lane, or element zero can be copied to all lanes when the operand comes from memory in broadcast form.

Each lane has a combinational rounding converter. The converter takes the magnitude, normalises it to an 11-bit significand, and rounds with guard and sticky information in one of four modes. Two rounding-control inputs exist, and the operand kind and vector length pick between them. A write mask with an enable, together with a zeroing/merge select, decides for each lane whether it takes the converted value, zero, or the prior destination half-word. Overflow and precision flags gather the events of all written lanes and stay set until reset.

The destination and the flags are registered. A result appears on the clock edge after its inputs are presented.

Top module: `i64_to_f16_pack`

## Requirements
- R1: The field `vl_sel_i` selects the active lane count: 0 gives 2 lanes, 1 gives 4 lanes, and 2 or 3 give 8 lanes. Lane j occupies `dst_o[16j+15:16j]`. Every half-word of an inactive lane reads zero.
- R2: When `src_mem_i`=1 and `bcast_i`=1, every active lane converts `src_i[63:0]`. In all other cases lane j converts `src_i[64j+63:64j]`.
- R3: The embedded rounding field `emb_rc_i` applies only when the source is a register (`src_mem_i`=0), 8 lanes are selected, and `bcast_i`=1. In every other case `glob_rc_i` applies.
- R4: Rounding code 0 is nearest with ties to even, 1 is toward minus infinity, 2 is toward plus infinity and 3 is toward zero. A round-up that carries out of the significand raises the exponent.
- R5: In merge mode (`zero_mode_i`=0), an active lane whose mask bit is clear keeps the matching half-word of `dst_old_i`.
- R6: In zeroing mode (`zero_mode_i`=1), an active lane whose mask bit is clear reads zero. When `kmask_en_i`=0, every active lane takes its converted value whatever `kmask_i` holds.
- R7: A magnitude that rounds above 65504 overflows. It gives infinity (0x7C00/0xFC00) under nearest-even and when rounding in the direction of the sign. Under toward-zero, or when rounding toward the opposite infinity, it gives ±65504 (0x7BFF/0xFBFF).
- R8: An overflow sets both `ovf_o` and `inexact_o`. A result that is inexact sets `inexact_o`. Only lanes that are written with a converted value contribute. Both flags stay set until reset.
- R9: An input of zero gives 0x0000 and raises no flag. The most negative 64-bit integer converts as a negative overflow.
- R10: The outputs update on the clock edge after the inputs. Reset clears `dst_o` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 512 | Packed signed 64-bit source elements |
| vl_sel_i | input | 2 | Vector-length select |
| bcast_i | input | 1 | Broadcast / embedded-rounding bit |
| src_mem_i | input | 1 | 1 = memory operand, 0 = register operand |
| emb_rc_i | input | 2 | Embedded rounding control |
| glob_rc_i | input | 2 | Global rounding control |
| kmask_i | input | 8 | Per-lane write mask |
| kmask_en_i | input | 1 | 1 = write mask in use |
| zero_mode_i | input | 1 | 1 = zeroing, 0 = merging |
| dst_old_i | input | 128 | Prior destination contents |
| dst_o | output | 128 | Packed half-precision result |
| ovf_o | output | 1 | Sticky overflow flag |
| inexact_o | output | 1 | Sticky precision flag |

## Verification
On every cycle the assertions check four things: the zeroed upper region for the two-lane length, merging and zeroing of a lane whose mask bit is clear, that the overflow flag stays set, and that the overflow flag implies the precision flag. The rest can only be shown by the bench's scenarios against its reference model. That covers the choice of rounding source, broadcast selection, ties and carries in each rounding mode, the saturation value for each mode, and the extreme inputs.

// File: rtl/i64f16_pkg.sv
package i64f16_pkg;
   typedef enum logic [1:0] {
      RND_NEAR = 2'd0,
      RND_DOWN = 2'd1,
      RND_UP   = 2'd2,
      RND_ZERO = 2'd3
   } rnd_t;

   localparam logic [14:0] H_INF_MAG  = 15'h7C00;
   localparam logic [14:0] H_MAX_MAG  = 15'h7BFF;
   localparam int          H_BIAS     = 15;
   localparam int          H_MAX_EXP  = 15;
   localparam int          H_SIG_BITS = 11;
endpackage

// File: rtl/i64f16_lane_cvt.sv
module i64f16_lane_cvt
   import i64f16_pkg::*;
#(
   parameter int IW = 64,
   parameter int HW = 16
) (
   input  logic [IW-1:0] val_i,
   input  rnd_t          rnd_i,
   output logic [HW-1:0] half_o,
   output logic          ovf_o,
   output logic          inx_o
);
   localparam int LW = $clog2(IW);

   if (IW != 64) begin : g_bad_iw
      $error("i64f16_lane_cvt: IW must be 64");
   end
   if (HW != 16) begin : g_bad_hw
      $error("i64f16_lane_cvt: HW must be 16");
   end

   logic          neg;
   logic [IW-1:0] mag;
   logic [LW-1:0] lead;
   logic [H_SIG_BITS-1:0] norm;
   logic          grd, stk, inc;
   logic [H_SIG_BITS:0]   sum;
   logic [LW:0]   ex;
   logic [IW-1:0] low_mask;

   always_comb begin
      neg  = val_i[IW-1];
      mag  = neg ? (~val_i + {{(IW-1){1'b0}}, 1'b1}) : val_i;
      lead = '0;
      for (int i = 0; i < IW; i++) begin
         if (mag[i]) lead = LW'(i);
      end
      grd      = 1'b0;
      stk      = 1'b0;
      low_mask = '0;
      if (lead <= LW'(H_SIG_BITS-1)) begin
         norm = H_SIG_BITS'(mag << (LW'(H_SIG_BITS-1) - lead));
      end else begin
         norm     = H_SIG_BITS'(mag >> (lead - LW'(H_SIG_BITS-1)));
         grd      = mag[lead - LW'(H_SIG_BITS)];
         low_mask = ({{(IW-1){1'b0}}, 1'b1} << (lead - LW'(H_SIG_BITS))) - 1'b1;
         stk      = |(mag & low_mask);
      end
      case (rnd_i)
         RND_NEAR: inc = grd & (stk | norm[0]);
         RND_DOWN: inc = neg & (grd | stk);
         RND_UP:   inc = ~neg & (grd | stk);
         default:  inc = 1'b0;
      endcase
      sum   = {1'b0, norm} + {{H_SIG_BITS{1'b0}}, inc};
      ex    = {1'b0, lead} + {{LW{1'b0}}, sum[H_SIG_BITS]};
      ovf_o = (mag != '0) && (ex > (LW+1)'(H_MAX_EXP));
      inx_o = grd | stk | ovf_o;
      if (mag == '0) begin
         half_o = '0;
      end else if (ovf_o) begin
         if (rnd_i == RND_NEAR || (rnd_i == RND_DOWN && neg) || (rnd_i == RND_UP && !neg))
            half_o = {neg, H_INF_MAG};
         else
            half_o = {neg, H_MAX_MAG};
      end else begin
         half_o = {neg, 5'(ex + (LW+1)'(H_BIAS)),
                   sum[H_SIG_BITS] ? 10'd0 : sum[H_SIG_BITS-2:0]};
      end
   end
endmodule

// File: rtl/i64f16_lane_wr.sv
module i64f16_lane_wr #(
   parameter int HW = 16
) (
   input  logic          active_i,
   input  logic          wr_i,
   input  logic          zero_mode_i,
   input  logic [HW-1:0] conv_i,
   input  logic [HW-1:0] old_i,
   input  logic          ovf_i,
   input  logic          inx_i,
   output logic [HW-1:0] half_o,
   output logic          ovf_o,
   output logic          inx_o
);
   logic take;

   always_comb begin
      take = active_i & wr_i;
      if (!active_i)     half_o = '0;
      else if (take)     half_o = conv_i;
      else if (zero_mode_i) half_o = '0;
      else               half_o = old_i;
      ovf_o = take & ovf_i;
      inx_o = take & inx_i;
   end
endmodule

// File: rtl/i64_to_f16_pack.sv
module i64_to_f16_pack
   import i64f16_pkg::*;
#(
   parameter int LANES = 8,
   parameter int IW    = 64,
   parameter int HW    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LANES*IW-1:0] src_i,
   input  logic [1:0]          vl_sel_i,
   input  logic                bcast_i,
   input  logic                src_mem_i,
   input  logic [1:0]          emb_rc_i,
   input  logic [1:0]          glob_rc_i,
   input  logic [LANES-1:0]    kmask_i,
   input  logic                kmask_en_i,
   input  logic                zero_mode_i,
   input  logic [LANES*HW-1:0] dst_old_i,
   output logic [LANES*HW-1:0] dst_o,
   output logic                ovf_o,
   output logic                inexact_o
);
   localparam int DW = LANES * HW;

   if (LANES != 8) begin : g_bad_lanes
      $error("i64_to_f16_pack: LANES must be 8");
   end

   logic [3:0]       n_act;
   logic             use_emb;
   rnd_t             rnd;
   logic [DW-1:0]    dst_nx;
   logic [LANES-1:0] ovf_l, inx_l;

   always_comb begin
      case (vl_sel_i)
         2'd0:    n_act = 4'd2;
         2'd1:    n_act = 4'd4;
         default: n_act = 4'd8;
      endcase
      use_emb = !src_mem_i && (n_act == 4'd8) && bcast_i;
      rnd     = rnd_t'(use_emb ? emb_rc_i : glob_rc_i);
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [IW-1:0] opnd;
      logic [HW-1:0] conv;
      logic          c_ovf, c_inx;

      assign opnd = (src_mem_i && bcast_i) ? src_i[IW-1:0] : src_i[j*IW +: IW];

      i64f16_lane_cvt #(.IW(IW), .HW(HW)) u_cvt (
         .val_i  (opnd),
         .rnd_i  (rnd),
         .half_o (conv),
         .ovf_o  (c_ovf),
         .inx_o  (c_inx)
      );

      i64f16_lane_wr #(.HW(HW)) u_wr (
         .active_i    (4'(j) < n_act),
         .wr_i        (!kmask_en_i || kmask_i[j]),
         .zero_mode_i (zero_mode_i),
         .conv_i      (conv),
         .old_i       (dst_old_i[j*HW +: HW]),
         .ovf_i       (c_ovf),
         .inx_i       (c_inx),
         .half_o      (dst_nx[j*HW +: HW]),
         .ovf_o       (ovf_l[j]),
         .inx_o       (inx_l[j])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_o     <= '0;
         ovf_o     <= 1'b0;
         inexact_o <= 1'b0;
      end else begin
         dst_o     <= dst_nx;
         ovf_o     <= ovf_o | (|ovf_l);
         inexact_o <= inexact_o | (|inx_l);
      end
   end

   // R1: two-lane length leaves the upper region zero
   a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (vl_sel_i == 2'd0) |=> (dst_o[DW-1:2*HW] == '0));

   // R5: merge keeps the old half-word of a masked-off lane
   a_r5_merge_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (kmask_en_i && !kmask_i[0] && !zero_mode_i) |=> (dst_o[HW-1:0] == $past(dst_old_i[HW-1:0])));

   // R6: zeroing clears a masked-off lane
   a_r6_zero_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (kmask_en_i && !kmask_i[0] && zero_mode_i) |=> (dst_o[HW-1:0] == '0));

   // R8: overflow flag is sticky and implies precision
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);
   a_r8_ovf_implies_inx: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> inexact_o);
endmodule

// File: tb/i64_to_f16_pack_test.sv
`timescale 1ns/1ps
module i64_to_f16_pack_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [511:0] src = '0;
   logic [1:0]   vl = 2'd2;
   logic         bc = 1'b0, mem = 1'b0;
   logic [1:0]   erc = 2'd0, grc = 2'd0;
   logic [7:0]   km = 8'hFF;
   logic         ken = 1'b0, zm = 1'b0;
   logic [127:0] old = '0;
   logic [127:0] dst;
   logic         ovf, inx;

   int  vectors = 0, errors = 0;
   bit  done = 0;
   logic [127:0] e_dst = '0;
   bit  e_ovf = 0, e_inx = 0;

   always #2.5 clk = ~clk;

   i64_to_f16_pack uut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .vl_sel_i(vl), .bcast_i(bc),
      .src_mem_i(mem), .emb_rc_i(erc), .glob_rc_i(grc), .kmask_i(km),
      .kmask_en_i(ken), .zero_mode_i(zm), .dst_old_i(old),
      .dst_o(dst), .ovf_o(ovf), .inexact_o(inx));

   function automatic logic [15:0] ref_cvt(input logic [63:0] v, input int rm,
                                           output bit ov, output bit px);
      bit neg = v[63];
      logic [63:0] mag = neg ? (64'd0 - v) : v;
      int e = -1;
      logic [63:0] q, r, half;
      bit up;
      ov = 0; px = 0;
      if (mag == 0) return 16'h0000;
      for (int i = 63; i >= 0; i--) if (e < 0 && mag >= (64'd1 << i)) e = i;
      if (e <= 10) begin
         q = mag << (10 - e);
         r = 0; half = 1;
      end else begin
         q = mag >> (e - 10);
         r = mag - (q << (e - 10));
         half = 64'd1 << (e - 11);
      end
      case (rm)
         0: up = (r > half) || (r == half && q[0]);
         1: up = neg && r != 0;
         2: up = !neg && r != 0;
         default: up = 0;
      endcase
      px = (r != 0);
      if (up) q = q + 1;
      if (q == 2048) begin q = 1024; e = e + 1; end
      if (e > 15) begin
         ov = 1; px = 1;
         if (rm == 0 || (rm == 1 && neg) || (rm == 2 && !neg))
            return neg ? 16'hFC00 : 16'h7C00;
         return neg ? 16'hFBFF : 16'h7BFF;
      end
      return {neg, 5'(e + 15), q[9:0]};
   endfunction

   task automatic model();
      int nl = (vl == 0) ? 2 : (vl == 1) ? 4 : 8;
      int rm = (!mem && nl == 8 && bc) ? int'(erc) : int'(grc);
      for (int j = 0; j < 8; j++) begin
         bit ov, px;
         logic [63:0] s;
         if (j >= nl) e_dst[j*16 +: 16] = 16'h0;
         else if (!ken || km[j]) begin
            s = (mem && bc) ? src[63:0] : src[j*64 +: 64];
            e_dst[j*16 +: 16] = ref_cvt(s, rm, ov, px);
            e_ovf |= ov; e_inx |= px;
         end else e_dst[j*16 +: 16] = zm ? 16'h0 : old[j*16 +: 16];
      end
   endtask

   task automatic step(input string tag);
      model();
      @(posedge clk); #1;
      vectors++;
      if (dst !== e_dst) begin
         errors++;
         $display("FAIL %s dst actual=%h expected=%h", tag, dst, e_dst);
      end
      vectors++;
      if (ovf !== e_ovf || inx !== e_inx) begin
         errors++;
         $display("FAIL %s flags actual ovf=%b inx=%b expected ovf=%b inx=%b",
                  tag, ovf, inx, e_ovf, e_inx);
      end
   endtask

   task automatic do_reset();
      rst_n = 0;
      @(posedge clk); @(posedge clk); #1;
      rst_n = 1;
      e_dst = '0; e_ovf = 0; e_inx = 0;
   endtask

   task automatic clean();
      vl = 2; bc = 0; mem = 0; erc = 0; grc = 0; km = 8'hFF; ken = 0; zm = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R10: reset state
      vectors++;
      if (dst !== '0 || ovf !== 0 || inx !== 0) begin
         errors++;
         $display("FAIL R10 reset actual=%h/%b/%b expected=0/0/0", dst, ovf, inx);
      end
      // R1: lane counts, upper region cleared
      for (int k = 0; k < 8; k++) src[k*64 +: 64] = 64'(k * 3 + 1);
      old = {8{16'hABCD}};
      for (int v = 0; v < 4; v++) begin clean(); vl = 2'(v); step("R1"); end
      // R2: broadcast from memory vs lane-wise
      clean(); mem = 1; bc = 1; vl = 1; step("R2");
      clean(); mem = 0; bc = 1; vl = 1; step("R2");
      clean(); mem = 1; bc = 0; step("R2");
      // R3: rounding source, inexact values
      do_reset();
      for (int k = 0; k < 8; k++) src[k*64 +: 64] = 64'd2049 + 64'(k);
      clean(); bc = 1; erc = 3; grc = 2; step("R3");
      clean(); bc = 1; mem = 1; erc = 3; grc = 2; step("R3");
      clean(); bc = 1; vl = 1; erc = 3; grc = 1; step("R3");
      // R4: ties, directed modes, carry out of significand
      src[0 +: 64] = 64'd2049;  src[64 +: 64] = 64'd2051;
      src[128 +: 64] = -64'sd2049; src[192 +: 64] = 64'd4095;
      src[256 +: 64] = 64'd2047; src[320 +: 64] = -64'sd4095;
      src[384 +: 64] = 64'd1; src[448 +: 64] = 64'h0000_0001_0000_0001;
      for (int m = 0; m < 4; m++) begin
         do_reset(); clean(); grc = 2'(m); step("R4");
      end
      // R5 / R6: masking
      old = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
      clean(); ken = 1; km = 8'b1010_0110; zm = 0; step("R5");
      clean(); ken = 1; km = 8'b0101_1001; zm = 1; step("R6");
      clean(); ken = 0; km = 8'h00; zm = 1; step("R6");
      clean(); ken = 1; km = 8'h00; zm = 0; vl = 1; step("R5");
      // R7: overflow saturation in every mode
      src[0 +: 64] = 64'd65519; src[64 +: 64] = 64'd65520;
      src[128 +: 64] = 64'd70000; src[192 +: 64] = -64'sd70000;
      src[256 +: 64] = -64'sd65520; src[320 +: 64] = 64'd65504;
      src[384 +: 64] = 64'h7FFF_FFFF_FFFF_FFFF; src[448 +: 64] = -64'sd65504;
      for (int m = 0; m < 4; m++) begin
         do_reset(); clean(); grc = 2'(m); step("R7");
      end
      // R8: exact values give no flag; masked-off overflow ignored; sticky
      do_reset();
      src[0 +: 64] = 64'd100; src[64 +: 64] = 64'd2048; src[128 +: 64] = 64'd70000;
      clean(); vl = 0; step("R8");
      clean(); ken = 1; km = 8'b1111_1011; step("R8");
      clean(); vl = 1; step("R8");
      src[128 +: 64] = 64'd5;
      clean(); vl = 0; step("R8");
      // R8: inexact alone sets precision only
      do_reset(); src[0 +: 64] = 64'd2049; clean(); vl = 0; step("R8");
      // R9: zero and most negative integer
      do_reset();
      src[0 +: 64] = 64'd0; src[64 +: 64] = 64'h8000_0000_0000_0000;
      clean(); vl = 0; ken = 1; km = 8'b01; step("R9");
      clean(); vl = 0; grc = 3; step("R9");
      // R10: latency, then reset clears
      clean(); step("R10");
      do_reset();
      vectors++;
      if (dst !== '0 || ovf !== 0 || inx !== 0) begin
         errors++;
         $display("FAIL R10 reset actual=%h/%b/%b expected=0/0/0", dst, ovf, inx);
      end
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule